// File: doc/BRIEF.md
# PCM Receive Channel with Signaling Extraction

This block receives one serial PCM sample per frame and turns it into an 8-bit parallel word. A frame-sync input marks where the word begins. The first bit is the most significant. The block runs in one of two rate modes, chosen by a mode-select input.

- **Fixed-rate mode:** a dedicated fixed data clock shifts the bits. The width of the frame-sync pulse, counted in data-clock periods, classifies the frame. A pulse one period wide marks an ordinary frame. A pulse two periods wide marks a signaling frame. In a signaling frame, the eighth bit is copied to a held signaling output.
- **Variable-rate mode:** a separate data clock shifts the bits. Frame sync acts as a timeslot enable, and bits are taken only while it is high.

Both data clocks are sampled as levels in the system clock domain, and their falling edges are detected there.

The block also watches for frame sync staying low. A programmable divider turns the system clock into frame periods. When frame sync has been low continuously for a set number of frame periods (240 by default, which is 30 ms at 8 kHz), the channel reports standby. The next frame-sync high clears standby.

Top module: `pcm_rx_port`

## Requirements
- R1: After reset, `pcm_word`, `word_valid`, `word_sig`, `sig_out` and `standby` are all 0.
- R2: In fixed-rate mode (`var_mode`=0), the first falling edge of `fix_clk` that sees `fsync` high captures the first bit. The next seven falling edges capture the rest, MSB first. In the system-clock cycle after the eighth falling edge is detected, the word appears on `pcm_word` and `word_valid` is high for exactly one cycle.
- R3: In fixed-rate mode, if `fsync` is high at only the first bit edge, the frame is ordinary: `word_sig`=0 with the word, and `sig_out` is unchanged.
- R4: In fixed-rate mode, if `fsync` is high at the first two bit edges, the frame is signaling: `word_sig`=1 with the word, and `sig_out` takes the eighth (last, LSB) bit.
- R5: `sig_out` changes only when a signaling frame completes. Ordinary frames and idle time leave it unchanged.
- R6: In variable-rate mode (`var_mode`=1), bits are captured on falling edges of `var_clk` only while `fsync` is high, MSB first. Each completed word gives a one-cycle `word_valid` with `word_sig`=0, and `sig_out` is unchanged.
- R7: In variable-rate mode, if `fsync` drops before eight bits are captured, the partial word is discarded. No `word_valid` follows, and the next word is assembled from fresh bits only.
- R8: The data clock of the mode that is not selected has no effect. Toggling it with `fsync` high produces no word.
- R9: With `fsync` held low, `standby` rises at the end of the 240th frame period. One frame period is `frame_div` system-clock cycles, counted from the first low cycle.
- R10: A cycle with `fsync` high clears `standby` and the frame timer. `standby` is 0 in the next cycle.
- R11: `pcm_word` changes only in a cycle where `word_valid` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| var_mode | input | 1 | 0 = fixed-rate mode, 1 = variable-rate mode |
| fix_clk | input | 1 | Fixed-rate data clock level |
| var_clk | input | 1 | Variable-rate data clock level |
| fsync | input | 1 | Frame sync / timeslot enable |
| sdata | input | 1 | Serial PCM data |
| frame_div | input | DIV_W | System-clock cycles per frame period |
| pcm_word | output | WORD_W | Last completed word |
| word_valid | output | 1 | One-cycle strobe for a new word |
| word_sig | output | 1 | The new word came from a signaling frame |
| sig_out | output | 1 | Held signaling bit |
| standby | output | 1 | Channel is in standby |

## Verification
Fixed-rate frames are sent in four combinations of pulse width and last bit: narrow with LSB 1, wide with LSB 1, narrow with LSB 0, and wide with LSB 0. This separates a correct width classification from one that ignores the second edge, and a latch that tracks every frame from one that tracks only signaling frames. In variable-rate mode, the bench sends a full timeslot, then a timeslot cut after five bits followed by a full one. This shows whether stale bits leak into the next word. Toggling the unselected clock with sync high exposes a wrong clock mux. The standby window is probed one cycle before and one cycle after its exact end, which catches off-by-one errors in the frame counter.

// File: rtl/pcm_rx_pkg.sv
package pcm_rx_pkg;
    // Rate mode encoding on var_mode
    typedef enum logic {
        RX_FIXED = 1'b0,
        RX_VAR   = 1'b1
    } rx_mode_e;

    // Frame-sync pulse width (in data-clock periods) that marks signaling
    localparam int unsigned SIG_PULSE_W = 2;
endpackage

// File: rtl/pcm_rx_edge.sv
module pcm_rx_edge
    import pcm_rx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic var_mode,
    input  logic fix_clk,
    input  logic var_clk,
    output logic bit_fall
);
    typedef struct packed {
        logic fix_prev;
        logic var_prev;
    } edge_st_t;

    edge_st_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.fix_prev = fix_clk;
        st_d.var_prev = var_clk;
        if (rx_mode_e'(var_mode) == RX_VAR) begin
            bit_fall = st_q.var_prev & ~var_clk;
        end else begin
            bit_fall = st_q.fix_prev & ~fix_clk;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/pcm_rx_shift.sv
module pcm_rx_shift
    import pcm_rx_pkg::*;
#(
    parameter int unsigned WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              var_mode,
    input  logic              bit_fall,
    input  logic              fsync,
    input  logic              sdata,
    output logic [WORD_W-1:0] word,
    output logic              valid,
    output logic              word_sig,
    output logic              sig_bit
);
    localparam int unsigned CNT_W = $clog2(WORD_W + 1);
    localparam int unsigned PW_W  = $clog2(SIG_PULSE_W + 1);

    typedef struct packed {
        logic              active;
        logic [CNT_W-1:0]  cnt;
        logic [WORD_W-1:0] sh;
        logic [PW_W-1:0]   pw;
        logic              pw_open;
        logic [WORD_W-1:0] word;
        logic              valid;
        logic              wsig;
        logic              sig;
    } shift_st_t;

    shift_st_t         st_d, st_q;
    logic [WORD_W-1:0] nxt_sh;
    logic              last_bit;
    logic [PW_W-1:0]   pw_nxt;

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        nxt_sh     = {st_q.sh[WORD_W-2:0], sdata};
        last_bit   = (st_q.cnt == CNT_W'(WORD_W - 1));
        pw_nxt     = st_q.pw;

        if (rx_mode_e'(var_mode) == RX_VAR) begin
            // Timeslot-enable behaviour
            if (st_q.active && !fsync) begin
                st_d.active = 1'b0;
                st_d.cnt    = '0;
            end else if (bit_fall && fsync) begin
                st_d.sh = nxt_sh;
                if (last_bit) begin
                    st_d.word   = nxt_sh;
                    st_d.valid  = 1'b1;
                    st_d.wsig   = 1'b0;
                    st_d.active = 1'b0;
                    st_d.cnt    = '0;
                end else begin
                    st_d.active = 1'b1;
                    st_d.cnt    = st_q.cnt + CNT_W'(1);
                end
            end
        end else begin
            // Fixed-rate: sync pulse starts the word and sets its class
            if (bit_fall && (st_q.active || fsync)) begin
                st_d.sh = nxt_sh;
                if (!st_q.active) begin
                    st_d.active  = 1'b1;
                    st_d.cnt     = CNT_W'(1);
                    st_d.pw      = PW_W'(1);
                    st_d.pw_open = 1'b1;
                end else begin
                    if (st_q.pw_open) begin
                        if (fsync) begin
                            if (st_q.pw != PW_W'(SIG_PULSE_W)) begin
                                pw_nxt = st_q.pw + PW_W'(1);
                            end
                        end else begin
                            st_d.pw_open = 1'b0;
                        end
                    end
                    st_d.pw = pw_nxt;
                    if (last_bit) begin
                        st_d.word    = nxt_sh;
                        st_d.valid   = 1'b1;
                        st_d.wsig    = (pw_nxt >= PW_W'(SIG_PULSE_W));
                        if (pw_nxt >= PW_W'(SIG_PULSE_W)) begin
                            st_d.sig = nxt_sh[0];
                        end
                        st_d.active  = 1'b0;
                        st_d.cnt     = '0;
                        st_d.pw_open = 1'b0;
                    end else begin
                        st_d.cnt = st_q.cnt + CNT_W'(1);
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign word     = st_q.word;
    assign valid    = st_q.valid;
    assign word_sig = st_q.wsig;
    assign sig_bit  = st_q.sig;
endmodule

// File: rtl/pcm_rx_standby.sv
module pcm_rx_standby #(
    parameter int unsigned DIV_W       = 16,
    parameter int unsigned STBY_FRAMES = 240
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fsync,
    input  logic [DIV_W-1:0] frame_div,
    output logic             standby
);
    localparam int unsigned FRM_W = $clog2(STBY_FRAMES + 1);

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic [FRM_W-1:0] frm;
        logic             stby;
    } stby_st_t;

    stby_st_t st_d, st_q;
    logic     tick;

    always_comb begin
        st_d = st_q;
        tick = (({1'b0, st_q.div} + {{DIV_W{1'b0}}, 1'b1}) >= {1'b0, frame_div});
        if (fsync) begin
            st_d.div  = '0;
            st_d.frm  = '0;
            st_d.stby = 1'b0;
        end else if (tick) begin
            st_d.div = '0;
            if (!st_q.stby) begin
                if (st_q.frm == FRM_W'(STBY_FRAMES - 1)) begin
                    st_d.stby = 1'b1;
                end else begin
                    st_d.frm = st_q.frm + FRM_W'(1);
                end
            end
        end else begin
            st_d.div = st_q.div + DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign standby = st_q.stby;
endmodule

// File: rtl/pcm_rx_port.sv
module pcm_rx_port #(
    parameter int unsigned WORD_W      = 8,
    parameter int unsigned DIV_W       = 16,
    parameter int unsigned STBY_FRAMES = 240
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              var_mode,
    input  logic              fix_clk,
    input  logic              var_clk,
    input  logic              fsync,
    input  logic              sdata,
    input  logic [DIV_W-1:0]  frame_div,
    output logic [WORD_W-1:0] pcm_word,
    output logic              word_valid,
    output logic              word_sig,
    output logic              sig_out,
    output logic              standby
);
    logic bit_fall;

    pcm_rx_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .var_mode (var_mode),
        .fix_clk  (fix_clk),
        .var_clk  (var_clk),
        .bit_fall (bit_fall)
    );

    pcm_rx_shift #(.WORD_W(WORD_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .var_mode (var_mode),
        .bit_fall (bit_fall),
        .fsync    (fsync),
        .sdata    (sdata),
        .word     (pcm_word),
        .valid    (word_valid),
        .word_sig (word_sig),
        .sig_bit  (sig_out)
    );

    pcm_rx_standby #(.DIV_W(DIV_W), .STBY_FRAMES(STBY_FRAMES)) u_stby (
        .clk       (clk),
        .rst_n     (rst_n),
        .fsync     (fsync),
        .frame_div (frame_div),
        .standby   (standby)
    );
endmodule

// File: rtl/pcm_rx_port_chk.sv
module pcm_rx_port_chk #(
    parameter int unsigned WORD_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              var_mode,
    input logic              fsync,
    input logic [WORD_W-1:0] pcm_word,
    input logic              word_valid,
    input logic              word_sig,
    input logic              sig_out,
    input logic              standby
);
    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |=> !word_valid); // R2

    AST_SIG_ONLY_ON_SIGFRAME: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sig_out) |-> (word_valid && word_sig)); // R5

    AST_VAR_NO_SIGFRAME: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && var_mode && $past(var_mode)) |-> !word_sig); // R6

    AST_STBY_RISE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(standby) |-> !$past(fsync)); // R9

    AST_STBY_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        fsync |=> !standby); // R10

    AST_WORD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pcm_word) |-> word_valid); // R11
endmodule

bind pcm_rx_port pcm_rx_port_chk #(.WORD_W(WORD_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .var_mode   (var_mode),
    .fsync      (fsync),
    .pcm_word   (pcm_word),
    .word_valid (word_valid),
    .word_sig   (word_sig),
    .sig_out    (sig_out),
    .standby    (standby)
);

// File: tb/pcm_rx_port_bench.sv
module pcm_rx_port_bench;
    localparam int DIV = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        var_mode = 1'b0;
    logic        fix_clk = 1'b0;
    logic        var_clk = 1'b0;
    logic        fsync = 1'b0;
    logic        sdata = 1'b0;
    logic [15:0] frame_div = 16'(DIV);
    logic [7:0]  pcm_word;
    logic        word_valid;
    logic        word_sig;
    logic        sig_out;
    logic        standby;

    int checks = 0;
    int errors = 0;
    int vcnt = 0;
    int dbl = 0;
    logic [7:0] lw = '0;
    logic       lsig = 1'b0;
    logic       vprev = 1'b0;

    always #5 clk = ~clk;

    pcm_rx_port u_pcm_rx_port (
        .clk(clk), .rst_n(rst_n), .var_mode(var_mode), .fix_clk(fix_clk),
        .var_clk(var_clk), .fsync(fsync), .sdata(sdata), .frame_div(frame_div),
        .pcm_word(pcm_word), .word_valid(word_valid), .word_sig(word_sig),
        .sig_out(sig_out), .standby(standby)
    );

    always @(negedge clk) begin
        if (word_valid) begin
            vcnt = vcnt + 1;
            lw   = pcm_word;
            lsig = word_sig;
            if (vprev) dbl = dbl + 1;
        end
        vprev = word_valid;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic fs, input logic sd, input logic on_var);
        @(negedge clk);
        fsync = fs; sdata = sd;
        if (on_var) var_clk = 1'b1; else fix_clk = 1'b1;
        repeat (2) @(negedge clk);
        if (on_var) var_clk = 1'b0; else fix_clk = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic fixed_frame(input logic [7:0] w, input logic wide,
                               input logic exp_sig, input string req);
        int c0 = vcnt;
        for (int i = 0; i < 8; i++) send_bit((i == 0) || (wide && i == 1), w[7-i], 1'b0);
        send_bit(1'b0, 1'b0, 1'b0);
        check({req, " R2 word count"}, vcnt - c0, 1);
        check({req, " R2 word"}, lw, w);
        check({req, " R3/R4 class"}, lsig, wide);
        check({req, " R5 sig_out"}, sig_out, exp_sig);
    endtask

    task automatic var_frame(input logic [7:0] w, input logic exp_sig);
        int c0 = vcnt;
        for (int i = 0; i < 8; i++) send_bit(1'b1, w[7-i], 1'b1);
        send_bit(1'b0, 1'b0, 1'b1);
        check("R6 word count", vcnt - c0, 1);
        check("R6 word", lw, w);
        check("R6 class", lsig, 1'b0);
        check("R6 sig_out held", sig_out, exp_sig);
    endtask

    task automatic test_var_abort();
        int c0 = vcnt;
        for (int i = 0; i < 5; i++) send_bit(1'b1, 1'b1, 1'b1);
        send_bit(1'b0, 1'b0, 1'b1);
        check("R7 no strobe on cut slot", vcnt - c0, 0);
        var_frame(8'h5A, sig_out);
        check("R7 fresh word after cut", lw, 8'h5A);
    endtask

    task automatic test_other_clock();
        int c0 = vcnt;
        var_mode = 1'b1;
        for (int i = 0; i < 9; i++) send_bit(1'b1, 1'b1, 1'b0);
        @(negedge clk); fsync = 1'b0;
        check("R8 fix_clk ignored in variable mode", vcnt - c0, 0);
        var_mode = 1'b0;
        for (int i = 0; i < 9; i++) send_bit(1'b1, 1'b1, 1'b1);
        @(negedge clk); fsync = 1'b0;
        repeat (2) @(negedge clk);
        check("R8 var_clk ignored in fixed mode", vcnt - c0, 0);
        check("R11 word held", pcm_word, 8'h5A);
    endtask

    task automatic test_standby();
        @(negedge clk); fsync = 1'b1;
        repeat (2) @(negedge clk);
        fsync = 1'b0;
        repeat (240 * DIV - 1) @(negedge clk);
        check("R9 standby not yet", standby, 1'b0);
        @(negedge clk);
        check("R9 standby entered", standby, 1'b1);
        fsync = 1'b1;
        @(negedge clk);
        check("R10 standby left", standby, 1'b0);
        fsync = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 word", pcm_word, 0);
        check("R1 valid", word_valid, 0);
        check("R1 class", word_sig, 0);
        check("R1 sig_out", sig_out, 0);
        check("R1 standby", standby, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        fixed_frame(8'hA5, 1'b0, 1'b0, "narrow A5");
        fixed_frame(8'h3B, 1'b1, 1'b1, "wide 3B");
        fixed_frame(8'h00, 1'b0, 1'b1, "narrow 00");
        fixed_frame(8'hC4, 1'b1, 1'b0, "wide C4");
        fixed_frame(8'h81, 1'b1, 1'b1, "wide 81");
        var_mode = 1'b1;
        var_frame(8'h96, 1'b1);
        test_var_abort();
        test_other_clock();
        test_standby();
        check("R2 strobe one cycle", dbl, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule